// File: doc/BRIEF.md
# Dual-Input Decade/Binary Up/Down Counter

This block is a presettable up/down counter with one count input for going up and another for going down. It counts in decade steps (0 to 9) by default. A parameter switches it to a plain binary counter that wraps at its all-ones value. Both count inputs come from outside the system clock domain and idle high. Each one passes through a synchronizer, and its rising edges are found on the system clock.

The counter has three more controls:
- A dominant clear, active high, empties the counter.
- A load input, active low, copies the preset word into the counter.
- Two active-low outputs, carry and borrow, mark the terminal count. Each is low only while its count input is in its low phase at the terminal value.

Because of this timing, stages chain directly. A stage's carry drives the next stage's up input, and its borrow drives the next stage's down input. In decade mode a counter holding a code from 10 to 15 returns to the legal range within one or two count steps.

Top module: `bcd_updown_counter`

## Requirements
- R1: While `clear_i` is high the count reads 0 and carry and borrow read 1, whatever the state of the load and count inputs. The clear acts without waiting for a clock edge.
- R2: While `load_n_i` is low (and clear is low), each system clock edge copies `preset_i` into the count, and count-input edges are ignored.
- R3: A rising edge on `up_i` adds one to the count on the third system clock edge after the input rises, but only if the synchronized `dn_i` level is high. If `dn_i` is low, the count is unchanged.
- R4: A rising edge on `dn_i` subtracts one on the third system clock edge after the input rises, but only if the synchronized `up_i` level is high.
- R5: If rising edges on both count inputs reach the counter in the same system cycle, the count is unchanged.
- R6: `carry_n_o` is 0 exactly when the count equals the maximum (9 in decade mode, 15 in binary mode) and the synchronized `up_i` level is low. It is 1 otherwise.
- R7: `borrow_n_o` is 0 exactly when the count is 0 and the synchronized `dn_i` level is low. It is 1 otherwise.
- R8: Counting up from the maximum gives 0. Counting down from 0 gives the maximum.
- R9: In decade mode, counting up from an illegal code moves as follows: 10 to 11, 11 to 6, 12 to 13, 13 to 4, 14 to 15, 15 to 2.
- R10: In decade mode, counting down from an illegal code moves as follows: 10 to 9, 11 to 10, 12 to 3, 13 to 12, 14 to 5, 15 to 14.
- R11: Two decade stages chain correctly when the low stage's carry and borrow drive the high stage's up and down inputs. Together they count 00 to 99 and wrap, both upward and downward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every input is sampled on it |
| clear_i | input | 1 | Dominant clear, active high, asynchronous |
| load_n_i | input | 1 | Parallel load, active low |
| preset_i | input | W | Value copied in by a load |
| up_i | input | 1 | Up count input, counts on its rising edge, idles high |
| dn_i | input | 1 | Down count input, counts on its rising edge, idles high |
| count_o | output | W | Current count |
| carry_n_o | output | 1 | Terminal count going up, active low |
| borrow_n_o | output | 1 | Terminal count going down, active low |

## Verification
The bench builds three decade instances with the defaults (W=4, decade mode, two-stage synchronizers) and one binary instance (W=4, binary mode). Every instance gets the same stimulus as its reference model. The binary instance makes the 15-to-0 wrap reachable, and loading the same preset codes there shows 10 to 15 as ordinary values. The decade instances reach the illegal-code recovery paths. Two of the decade instances are wired in cascade, so the carry and borrow timing is exercised by a real downstream counter across every 9-to-0 and 0-to-9 rollover.

// File: rtl/bcd_ud_pkg.sv
package bcd_ud_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2,
    STEP_LOAD = 2'd3
  } step_e;

  // Decade successor, including the recovery path for codes 10..15.
  function automatic logic [3:0] dec_succ(input logic [3:0] v);
    logic [3:0] r;
    case (v)
      4'd9:    r = 4'd0;
      4'd10:   r = 4'd11;
      4'd11:   r = 4'd6;
      4'd12:   r = 4'd13;
      4'd13:   r = 4'd4;
      4'd14:   r = 4'd15;
      4'd15:   r = 4'd2;
      default: r = v + 4'd1;
    endcase
    return r;
  endfunction

  // Decade predecessor, including the recovery path for codes 10..15.
  function automatic logic [3:0] dec_pred(input logic [3:0] v);
    logic [3:0] r;
    case (v)
      4'd0:    r = 4'd9;
      4'd10:   r = 4'd9;
      4'd11:   r = 4'd10;
      4'd12:   r = 4'd3;
      4'd13:   r = 4'd12;
      4'd14:   r = 4'd5;
      4'd15:   r = 4'd14;
      default: r = v - 4'd1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/bcd_ud_sync_edge.sv
module bcd_ud_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr,
  input  logic din,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  // Synchronizer chain; idle level of a count input is high.
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or posedge clr) begin
        if (clr) chain_q[0] <= 1'b1;
        else     chain_q[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or posedge clr) begin
        if (clr) chain_q[s] <= 1'b1;
        else     chain_q[s] <= chain_q[s-1];
      end
    end
  end

  always_ff @(posedge clk or posedge clr) begin
    if (clr) prev_q <= 1'b1;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/bcd_ud_step.sv
module bcd_ud_step
  import bcd_ud_pkg::*;
#(
  parameter int W      = 4,
  parameter bit DECADE = 1'b1
) (
  input  logic [W-1:0] cur_i,
  input  step_e        step_i,
  input  logic [W-1:0] preset_i,
  output logic [W-1:0] nxt_o
);
  logic [W-1:0] succ_w;
  logic [W-1:0] pred_w;

  if (DECADE) begin : g_decade
    assign succ_w = dec_succ(cur_i);
    assign pred_w = dec_pred(cur_i);
  end else begin : g_binary
    assign succ_w = cur_i + 1'b1;
    assign pred_w = cur_i - 1'b1;
  end

  always_comb begin
    case (step_i)
      STEP_UP:   nxt_o = succ_w;
      STEP_DOWN: nxt_o = pred_w;
      STEP_LOAD: nxt_o = preset_i;
      default:   nxt_o = cur_i;
    endcase
  end

endmodule

// File: rtl/bcd_updown_counter.sv
module bcd_updown_counter
  import bcd_ud_pkg::*;
#(
  parameter int W           = 4,
  parameter bit DECADE      = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         clear_i,
  input  logic         load_n_i,
  input  logic [W-1:0] preset_i,
  input  logic         up_i,
  input  logic         dn_i,
  output logic [W-1:0] count_o,
  output logic         carry_n_o,
  output logic         borrow_n_o
);
  localparam logic [W-1:0] TOP  = DECADE ? W'(9) : {W{1'b1}};
  localparam logic [W-1:0] NINE = W'(9);

  logic         up_lvl, up_rise, dn_lvl, dn_rise;
  logic         both_rise;
  step_e        step;
  logic [W-1:0] count_q, count_nxt;

  bcd_ud_sync_edge #(.STAGES(SYNC_STAGES)) u_up_sync (
    .clk(clk), .clr(clear_i), .din(up_i), .level_o(up_lvl), .rise_o(up_rise)
  );

  bcd_ud_sync_edge #(.STAGES(SYNC_STAGES)) u_dn_sync (
    .clk(clk), .clr(clear_i), .din(dn_i), .level_o(dn_lvl), .rise_o(dn_rise)
  );

  assign both_rise = up_rise & dn_rise;

  // Priority: load, then simultaneous edges, then up, then down.
  always_comb begin
    if (!load_n_i)                step = STEP_LOAD;
    else if (both_rise)           step = STEP_HOLD;
    else if (up_rise && dn_lvl)   step = STEP_UP;
    else if (dn_rise && up_lvl)   step = STEP_DOWN;
    else                          step = STEP_HOLD;
  end

  bcd_ud_step #(.W(W), .DECADE(DECADE)) u_step (
    .cur_i(count_q), .step_i(step), .preset_i(preset_i), .nxt_o(count_nxt)
  );

  always_ff @(posedge clk or posedge clear_i) begin
    if (clear_i) count_q <= '0;
    else         count_q <= count_nxt;
  end

  assign count_o    = count_q;
  assign carry_n_o  = ~((count_q == TOP) & ~up_lvl);
  assign borrow_n_o = ~((count_q == '0) & ~dn_lvl);

  // ---------------- assertions ----------------
  assert_clear_zero_R1: assert property (@(posedge clk)
    clear_i |-> (count_o == '0 && carry_n_o && borrow_n_o));

  assert_load_copies_R2: assert property (@(posedge clk) disable iff (clear_i)
    !load_n_i |=> count_o == $past(preset_i));

  assert_up_step_R3: assert property (@(posedge clk) disable iff (clear_i)
    (step == STEP_UP && count_q < TOP) |=> count_o == $past(count_q) + 1'b1);

  assert_up_blocked_R3: assert property (@(posedge clk) disable iff (clear_i)
    (load_n_i && !dn_lvl && !dn_rise) |=> $stable(count_o));

  assert_down_step_R4: assert property (@(posedge clk) disable iff (clear_i)
    (step == STEP_DOWN && count_q != '0 && count_q <= TOP) |=> count_o == $past(count_q) - 1'b1);

  assert_both_hold_R5: assert property (@(posedge clk) disable iff (clear_i)
    (both_rise && load_n_i) |=> $stable(count_o));

  assert_carry_at_top_R6: assert property (@(posedge clk) disable iff (clear_i)
    !carry_n_o |-> count_o == TOP);

  assert_borrow_at_zero_R7: assert property (@(posedge clk) disable iff (clear_i)
    !borrow_n_o |-> count_o == '0);

  assert_wrap_up_R8: assert property (@(posedge clk) disable iff (clear_i)
    (step == STEP_UP && count_q == TOP) |=> count_o == '0);

  assert_wrap_down_R8: assert property (@(posedge clk) disable iff (clear_i)
    (step == STEP_DOWN && count_q == '0) |=> count_o == TOP);

  if (DECADE) begin : g_dec_chk
    assert_odd_illegal_up_R9: assert property (@(posedge clk) disable iff (clear_i)
      (step == STEP_UP && count_q > NINE && count_q[0]) |=> count_o <= NINE);
    assert_illegal_down_R10: assert property (@(posedge clk) disable iff (clear_i)
      (step == STEP_DOWN && count_q > NINE) |=> (count_o <= NINE || count_o[0] == 1'b0));
  end

endmodule

// File: tb/bcd_updown_counter_tb.sv
`timescale 1ns/1ps
module bcd_updown_counter_tb;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       clear, load_n, up, dn;
  logic [3:0] preset;
  logic [3:0] cnt_d, cnt_b;
  logic       cy_d, bo_d, cy_b, bo_b;

  logic       c_clear, c_up, c_dn;
  logic [3:0] lo_cnt, hi_cnt;
  logic       lo_cy, lo_bo, hi_cy, hi_bo;

  int    vectors = 0;
  int    miscompares = 0;
  bit    checking = 0;
  string req = "R1";

  bcd_updown_counter #(.W(4), .DECADE(1'b1)) u_dut (
    .clk(clk), .clear_i(clear), .load_n_i(load_n), .preset_i(preset),
    .up_i(up), .dn_i(dn), .count_o(cnt_d), .carry_n_o(cy_d), .borrow_n_o(bo_d));

  bcd_updown_counter #(.W(4), .DECADE(1'b0)) u_bin (
    .clk(clk), .clear_i(clear), .load_n_i(load_n), .preset_i(preset),
    .up_i(up), .dn_i(dn), .count_o(cnt_b), .carry_n_o(cy_b), .borrow_n_o(bo_b));

  bcd_updown_counter #(.W(4), .DECADE(1'b1)) u_lo (
    .clk(clk), .clear_i(c_clear), .load_n_i(1'b1), .preset_i(4'd0),
    .up_i(c_up), .dn_i(c_dn), .count_o(lo_cnt), .carry_n_o(lo_cy), .borrow_n_o(lo_bo));

  bcd_updown_counter #(.W(4), .DECADE(1'b1)) u_hi (
    .clk(clk), .clear_i(c_clear), .load_n_i(1'b1), .preset_i(4'd0),
    .up_i(lo_cy), .dn_i(lo_bo), .count_o(hi_cnt), .carry_n_o(hi_cy), .borrow_n_o(hi_bo));

  // ---------------- reference model ----------------
  int m [2];
  int u1, u2, pu, d1, d2, pd;

  function automatic int ref_up(int v, bit dec);
    if (!dec) return (v + 1) % 16;
    case (v)
      9: return 0;   10: return 11; 11: return 6;
      12: return 13; 13: return 4;  14: return 15; 15: return 2;
      default: return v + 1;
    endcase
  endfunction

  function automatic int ref_dn(int v, bit dec);
    if (!dec) return (v + 15) % 16;
    case (v)
      0: return 9;   10: return 9;  11: return 10;
      12: return 3;  13: return 12; 14: return 5;  15: return 14;
      default: return v - 1;
    endcase
  endfunction

  always @(posedge clk) begin
    if (clear) begin
      m[0] = 0; m[1] = 0;
      u1 = 1; u2 = 1; pu = 1; d1 = 1; d2 = 1; pd = 1;
    end else begin
      bit eu, ed;
      eu = (u2 == 1) && (pu == 0);
      ed = (d2 == 1) && (pd == 0);
      for (int i = 0; i < 2; i++) begin
        if (!load_n)                m[i] = int'(preset);
        else if (eu && ed)          m[i] = m[i];
        else if (eu && d2 == 1)     m[i] = ref_up(m[i], i == 0);
        else if (ed && u2 == 1)     m[i] = ref_dn(m[i], i == 0);
      end
      pu = u2; u2 = u1; u1 = int'(up);
      pd = d2; d2 = d1; d1 = int'(dn);
    end
  end

  task automatic compare(int act, int exp, string what);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      int top_d, top_b;
      top_d = 9; top_b = 15;
      compare(int'(cnt_d), m[0], "decade count");
      compare(int'(cy_d), (m[0] == top_d && u2 == 0) ? 0 : 1, "decade carry R6");
      compare(int'(bo_d), (m[0] == 0 && d2 == 0) ? 0 : 1, "decade borrow R7");
      compare(int'(cnt_b), m[1], "binary count");
      compare(int'(cy_b), (m[1] == top_b && u2 == 0) ? 0 : 1, "binary carry R6");
      compare(int'(bo_b), (m[1] == 0 && d2 == 0) ? 0 : 1, "binary borrow R7");
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_up();
    up = 1'b0; tick(4); up = 1'b1; tick(5);
  endtask

  task automatic pulse_dn();
    dn = 1'b0; tick(4); dn = 1'b1; tick(5);
  endtask

  task automatic c_pulse(bit go_up, int expect_val);
    if (go_up) c_up = 1'b0; else c_dn = 1'b0;
    tick(4);
    if (go_up) c_up = 1'b1; else c_dn = 1'b1;
    tick(7);
    compare(int'(hi_cnt) * 10 + int'(lo_cnt), expect_val, "cascade value R11");
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  // ---------------- test sequence ----------------
  initial begin
    clear = 1'b1; load_n = 1'b1; preset = 4'd0; up = 1'b1; dn = 1'b1;
    c_clear = 1'b1; c_up = 1'b1; c_dn = 1'b1;
    tick(3);
    checking = 1'b1;
    req = "R1";
    compare(int'(cnt_d), 0, "reset count R1");
    compare(int'(cy_d), 1, "reset carry R1");
    compare(int'(bo_d), 1, "reset borrow R1");
    clear = 1'b0; c_clear = 1'b0;
    tick(2);

    req = "R3 R6 R8";
    for (int k = 0; k < 20; k++) pulse_up();
    req = "R4 R7 R8";
    for (int k = 0; k < 20; k++) pulse_dn();

    req = "R3 gating";
    dn = 1'b0; tick(4);
    up = 1'b0; tick(4); up = 1'b1; tick(5);
    compare(int'(cnt_d), m[0], "up blocked by low down R3");
    dn = 1'b1; tick(5);
    req = "R4 gating";
    up = 1'b0; tick(4);
    dn = 1'b0; tick(4); dn = 1'b1; tick(5);
    up = 1'b1; tick(5);

    req = "R5";
    pulse_up(); pulse_up();
    up = 1'b0; dn = 1'b0; tick(4);
    up = 1'b1; dn = 1'b1; tick(5);
    compare(int'(cnt_d), 2, "simultaneous edges hold R5");

    req = "R2";
    pulse_up();
    preset = 4'd7; load_n = 1'b0;
    pulse_up(); pulse_dn();
    tick(1);
    compare(int'(cnt_d), 7, "load holds preset R2");
    load_n = 1'b1; tick(1);
    pulse_up();
    compare(int'(cnt_d), 8, "count after load R2");

    req = "R1";
    preset = 4'd5; load_n = 1'b0; clear = 1'b1;
    up = 1'b0; tick(3); up = 1'b1; tick(3);
    compare(int'(cnt_d), 0, "clear over load R1");
    clear = 1'b0; load_n = 1'b1; tick(3);

    for (int v = 10; v < 16; v++) begin
      req = "R9";
      preset = 4'(v); load_n = 1'b0; tick(2); load_n = 1'b1; tick(1);
      pulse_up();
      req = "R10";
      preset = 4'(v); load_n = 1'b0; tick(2); load_n = 1'b1; tick(1);
      pulse_dn(); pulse_dn();
    end
    req = "R9";
    preset = 4'd13; load_n = 1'b0; tick(2); load_n = 1'b1; tick(1);
    pulse_up();
    compare(int'(cnt_d), 4, "13 up gives 4 R9");
    req = "R10";
    preset = 4'd14; load_n = 1'b0; tick(2); load_n = 1'b1; tick(1);
    pulse_dn();
    compare(int'(cnt_d), 5, "14 down gives 5 R10");

    req = "R11";
    for (int k = 1; k <= 100; k++) c_pulse(1'b1, k % 100);
    for (int k = 99; k >= 0; k--) c_pulse(1'b0, k);

    tick(2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule